// File: doc/BRIEF.md
# Indirect Byte-Wise Bus Access Bridge

This block gives a host a path into a 32-bit internal memory bus when the host can only issue byte-wide register accesses to a configuration index space. The host writes the target address and the data word one byte at a time into separate index registers and picks an access size. It then starts a single bus cycle through a trigger register. Writing a fixed key value to the trigger starts a bus write. Reading the trigger starts a bus read, and the returned word is read back byte by byte afterwards.

Address bytes are entered most significant first. Data bytes are also entered most significant first as the host sees them, but they are swapped on the way to and from the bus, because the bus side holds little-endian values. The bridge works only while its device-activate input is high. It drives one outstanding request at a time on a request/ready master port.

Top module: `sio_bus_bridge`

## Requirements
- R1: After reset the bus request is low. The address and data index registers read back as 0x00, and the size register reads back as 2.
- R2: Index 0xF0 holds bus address bits 31:24, 0xF1 holds bits 23:16, 0xF2 holds bits 15:8 and 0xF3 holds bits 7:0. The address of a started cycle is the value assembled from these four bytes.
- R3: On a write cycle, index 0xF4 drives bus data lane bits 7:0, 0xF5 drives bits 15:8, 0xF6 drives bits 23:16 and 0xF7 drives bits 31:24.
- R4: The low two bits of the byte written to index 0xF8 set the size. Code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes, with code 3 shown on the bus size output as 2. On a write cycle, lanes outside the size are driven as zero.
- R5: Writing 0xCF to index 0xFE while idle raises the bus request with the write flag set on the next clock. Any other value written there starts nothing.
- R6: Reading index 0xFE while idle starts a read cycle on the next clock. That read returns 0x01 if a cycle is outstanding and 0x00 otherwise.
- R7: The request stays high, with address, data, size and write flag unchanged, until the clock edge at which ready is high. It is low on the following clock.
- R8: When a read cycle completes, bus lanes 7:0, 15:8, 23:16 and 31:24 are loaded into indexes 0xF4, 0xF5, 0xF6 and 0xF7. Lanes outside the size are loaded as zero.
- R9: A trigger, by key write or by read, that arrives while a cycle is outstanding starts no further cycle.
- R10: While the device-activate input is low, index writes are ignored, triggers start nothing, and reads return 0x00.
- R11: Indexes 0xF0 to 0xF8 read back their stored value (the size as its stored 2-bit code). Any other index except 0xFE reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_active | input | 1 | Device activate bit; bridge operates only when high |
| cfg_wr | input | 1 | Index write strobe |
| cfg_rd | input | 1 | Index read strobe |
| cfg_idx | input | 8 | Decoded index within the device space |
| cfg_wdata | input | 8 | Byte written by the host |
| cfg_rdata | output | 8 | Byte returned to the host during a read strobe |
| bus_req | output | 1 | Bus request, held until ready |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data, little-endian lanes |
| bus_size | output | 2 | Access size: 0 byte, 1 half word, 2 word |
| bus_ready | input | 1 | Bus completes the cycle at an edge where this is high |
| bus_rdata | input | 32 | Bus read data, valid with ready |

## Verification
The bench builds the bridge with its default parameters: four byte lanes and the 0xF0 to 0xFE index layout with trigger key 0xCF. With these, every size code, including the aliased code 3, is reachable, as is the lane masking in both directions. The bench's bus responder changes its ready latency from zero to six cycles. This exposes the hold behaviour of the request and makes room for triggers that land while a cycle is still outstanding.

// File: rtl/sio_bridge_pkg.sv
package sio_bridge_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Size code 3 is an alias of the full word.
    function automatic logic [1:0] norm_size(input logic [1:0] code);
        return (code == 2'd3) ? SZ_WORD : code;
    endfunction

    // True when byte lane k takes part in an access of the given size.
    function automatic logic lane_en(input logic [1:0] sz, input int unsigned k);
        return k < (32'd1 << sz);
    endfunction

endpackage

// File: rtl/sio_bridge_regs.sv
module sio_bridge_regs
    import sio_bridge_pkg::*;
#(
    parameter int unsigned NBYTES   = 4,
    parameter logic [7:0]  IDX_ADDR = 8'hF0,
    parameter logic [7:0]  IDX_DATA = 8'hF4,
    parameter logic [7:0]  IDX_SIZE = 8'hF8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             idx,
    input  logic [7:0]             wdata,
    input  logic                   load_en,
    input  logic [NBYTES-1:0][7:0] load_bytes,
    output logic [NBYTES-1:0][7:0] addr_bytes,
    output logic [NBYTES-1:0][7:0] data_bytes,
    output logic [1:0]             size_code,
    output logic [7:0]             rdata
);

    typedef struct packed {
        logic [NBYTES-1:0][7:0] addr;  // addr[n] is address byte n (bits 8n+7:8n)
        logic [NBYTES-1:0][7:0] data;  // data[k] is index IDX_DATA+k, bus lane k
        logic [1:0]             size;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int unsigned k = 0; k < NBYTES; k++) begin
                if (idx == 8'(IDX_ADDR + k)) s_d.addr[NBYTES-1-k] = wdata;
                if (idx == 8'(IDX_DATA + k)) s_d.data[k] = wdata;
            end
            if (idx == IDX_SIZE) s_d.size = wdata[1:0];
        end
        // A completing read overrides a host write in the same cycle.
        if (load_en) s_d.data = load_bytes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.addr <= '0;
            s_q.data <= '0;
            s_q.size <= SZ_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int unsigned k = 0; k < NBYTES; k++) begin
            if (idx == 8'(IDX_ADDR + k)) rdata = s_q.addr[NBYTES-1-k];
            if (idx == 8'(IDX_DATA + k)) rdata = s_q.data[k];
        end
        if (idx == IDX_SIZE) rdata = {6'b0, s_q.size};
    end

    assign addr_bytes = s_q.addr;
    assign data_bytes = s_q.data;
    assign size_code  = s_q.size;

endmodule

// File: rtl/sio_bridge_master.sv
module sio_bridge_master #(
    parameter int unsigned NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_wr,
    input  logic                  start_rd,
    input  logic [8*NBYTES-1:0]   addr_in,
    input  logic [8*NBYTES-1:0]   wdata_in,
    input  logic [1:0]            size_in,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [8*NBYTES-1:0]   bus_addr,
    output logic [8*NBYTES-1:0]   bus_wdata,
    output logic [1:0]            bus_size,
    input  logic                  bus_ready,
    output logic                  rd_done,
    output logic                  busy
);

    localparam int unsigned W = 8 * NBYTES;

    typedef struct packed {
        logic         req;
        logic         we;
        logic [W-1:0] addr;
        logic [W-1:0] wdata;
        logic [1:0]   size;
    } mst_t;

    mst_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        rd_done = 1'b0;
        if (s_q.req) begin
            if (bus_ready) begin
                s_d.req = 1'b0;
                rd_done = !s_q.we;
            end
        end else if (start_wr || start_rd) begin
            s_d.req   = 1'b1;
            s_d.we    = start_wr;
            s_d.addr  = addr_in;
            s_d.wdata = start_wr ? wdata_in : '0;
            s_d.size  = size_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_req   = s_q.req;
    assign bus_we    = s_q.we;
    assign bus_addr  = s_q.addr;
    assign bus_wdata = s_q.wdata;
    assign bus_size  = s_q.size;
    assign busy      = s_q.req;

endmodule

// File: rtl/sio_bus_bridge.sv
module sio_bus_bridge
    import sio_bridge_pkg::*;
#(
    parameter int unsigned NBYTES   = 4,
    parameter logic [7:0]  IDX_ADDR = 8'hF0,
    parameter logic [7:0]  IDX_DATA = 8'hF4,
    parameter logic [7:0]  IDX_SIZE = 8'hF8,
    parameter logic [7:0]  IDX_TRIG = 8'hFE,
    parameter logic [7:0]  TRIG_KEY = 8'hCF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dev_active,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    input  logic [7:0]            cfg_idx,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [8*NBYTES-1:0]   bus_addr,
    output logic [8*NBYTES-1:0]   bus_wdata,
    output logic [1:0]            bus_size,
    input  logic                  bus_ready,
    input  logic [8*NBYTES-1:0]   bus_rdata
);

    localparam int unsigned W = 8 * NBYTES;

    logic                   wr_ok, rd_ok, start_wr, start_rd;
    logic                   busy, rd_done;
    logic [NBYTES-1:0][7:0] addr_bytes, data_bytes, load_bytes;
    logic [1:0]             size_code, size_n;
    logic [7:0]             reg_rdata;
    logic [W-1:0]           wr_lanes;

    assign wr_ok    = cfg_wr && dev_active;
    assign rd_ok    = cfg_rd && dev_active;
    assign start_wr = wr_ok && (cfg_idx == IDX_TRIG) && (cfg_wdata == TRIG_KEY);
    assign start_rd = rd_ok && (cfg_idx == IDX_TRIG);
    assign size_n   = norm_size(size_code);

    sio_bridge_regs #(
        .NBYTES   (NBYTES),
        .IDX_ADDR (IDX_ADDR),
        .IDX_DATA (IDX_DATA),
        .IDX_SIZE (IDX_SIZE)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .load_en    (rd_done),
        .load_bytes (load_bytes),
        .addr_bytes (addr_bytes),
        .data_bytes (data_bytes),
        .size_code  (size_code),
        .rdata      (reg_rdata)
    );

    // Host byte IDX_DATA+k sits on bus lane k in both directions.
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign wr_lanes[8*k +: 8] = lane_en(size_n, k)   ? data_bytes[k]        : 8'h00;
        assign load_bytes[k]      = lane_en(bus_size, k) ? bus_rdata[8*k +: 8]  : 8'h00;
    end

    sio_bridge_master #(
        .NBYTES (NBYTES)
    ) i_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .addr_in   (addr_bytes),
        .wdata_in  (wr_lanes),
        .size_in   (size_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_size  (bus_size),
        .bus_ready (bus_ready),
        .rd_done   (rd_done),
        .busy      (busy)
    );

    always_comb begin
        cfg_rdata = 8'h00;
        if (rd_ok) cfg_rdata = (cfg_idx == IDX_TRIG) ? {7'b0, busy} : reg_rdata;
    end

endmodule

// File: rtl/sio_bus_bridge_chk.sv
module sio_bus_bridge_chk #(
    parameter int unsigned NBYTES   = 4,
    parameter logic [7:0]  IDX_TRIG = 8'hFE,
    parameter logic [7:0]  TRIG_KEY = 8'hCF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dev_active,
    input logic                cfg_wr,
    input logic                cfg_rd,
    input logic [7:0]          cfg_idx,
    input logic [7:0]          cfg_wdata,
    input logic [7:0]          cfg_rdata,
    input logic                bus_req,
    input logic                bus_we,
    input logic [8*NBYTES-1:0] bus_addr,
    input logic [8*NBYTES-1:0] bus_wdata,
    input logic [1:0]          bus_size,
    input logic                bus_ready
);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                  && $stable(bus_we) && $stable(bus_size));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ready |=> !bus_req);

    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active && !bus_req |=> !bus_req);

    a_r10_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd && dev_active) |-> cfg_rdata == 8'h00);

    a_r5_key_start: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && dev_active && cfg_wr && cfg_idx == IDX_TRIG && cfg_wdata == TRIG_KEY
        |=> bus_req && bus_we);

    a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && cfg_wr && !cfg_rd && cfg_idx == IDX_TRIG && cfg_wdata != TRIG_KEY
        |=> !bus_req);

    a_r4_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_size == 2'd0 |-> bus_wdata[8*NBYTES-1:8] == '0);

    a_r4_size_range: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_size != 2'd3);

endmodule

bind sio_bus_bridge sio_bus_bridge_chk #(
    .NBYTES   (NBYTES),
    .IDX_TRIG (IDX_TRIG),
    .TRIG_KEY (TRIG_KEY)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_active (dev_active),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_size   (bus_size),
    .bus_ready  (bus_ready)
);

// File: tb/test_sio_bus_bridge.sv
module test_sio_bus_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_active = 1'b1;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_idx = 8'h00, cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        bus_req, bus_we, bus_ready = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic [31:0] rd_word = 32'h0;

    int n_chk = 0, n_fail = 0, n_hs = 0, lat = 0, rcnt = 0;
    bit finished = 0;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  size;
    } txn_t;
    txn_t exp_q[$];

    always #5 clk = ~clk;
    assign bus_rdata = rd_word;

    sio_bus_bridge i_sio_bus_bridge (
        .clk(clk), .rst_n(rst_n), .dev_active(dev_active),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus responder: ready after lat extra cycles.
    always @(negedge clk) begin
        if (!bus_req) begin
            rcnt = 0;
            bus_ready = 1'b0;
        end else if (!bus_ready) begin
            bus_ready = (rcnt >= lat);
            rcnt++;
        end
    end

    // Monitor: pops expected cycles at each handshake (R2 R3 R4 R7).
    int hcnt = 0;
    always @(posedge clk) begin
        if (rst_n && bus_req) begin
            hcnt++;
            if (bus_ready) begin
                txn_t got, exp;
                got = {bus_we, bus_addr, bus_wdata, bus_size};
                n_hs++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected cycle", 72'(got), 72'(0));
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, "R2/R3/R4 bus cycle", 72'(got), 72'(exp));
                end
                check(hcnt == lat + 1, "R7 request held until ready", 72'(hcnt), 72'(lat + 1));
                hcnt = 0;
            end
        end
    end

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] val);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = idx;
        #1 val = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && bus_req; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_regs(input logic [31:0] addr, input logic [31:0] host, input logic [1:0] sz);
        for (int k = 0; k < 4; k++) cfg_write(8'(8'hF0 + k), addr[31-8*k -: 8]);
        for (int k = 0; k < 4; k++) cfg_write(8'(8'hF4 + k), host[31-8*k -: 8]);
        cfg_write(8'hF8, {6'b0, sz});
    endtask

    function automatic logic [1:0] nsz(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        case (nsz(sz))
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic do_write(input logic [31:0] addr, input logic [31:0] host, input logic [1:0] sz);
        logic [31:0] sw;
        sw = {host[7:0], host[15:8], host[23:16], host[31:24]} & lane_mask(sz);
        load_regs(addr, host, sz);
        exp_q.push_back({1'b1, addr, sw, nsz(sz)});
        cfg_write(8'hFE, 8'hCF);
        check(bus_req && bus_we, "R5 key write starts write", 72'({bus_req, bus_we}), 72'(3));
        wait_idle();
    endtask

    task automatic do_read(input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] word);
        logic [7:0] v;
        logic [31:0] m;
        load_regs(addr, 32'h0, sz);
        rd_word = word;
        m = word & lane_mask(sz);
        exp_q.push_back({1'b0, addr, 32'h0, nsz(sz)});
        cfg_read(8'hFE, v);
        check(v == 8'h00, "R6 trigger read returns idle", 72'(v), 72'(0));
        check(bus_req && !bus_we, "R6 read cycle started", 72'({bus_req, bus_we}), 72'(2));
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            cfg_read(8'(8'hF4 + k), v);
            check(v == m[8*k +: 8], "R8 returned byte", 72'(v), 72'(m[8*k +: 8]));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(!bus_req, "R1 request low", 72'(bus_req), 72'(0));
        for (int k = 0; k < 8; k++) begin
            cfg_read(8'(8'hF0 + k), v);
            check(v == 8'h00, "R1 index register zero", 72'(v), 72'(0));
        end
        cfg_read(8'hF8, v);
        check(v == 8'h02, "R1 size resets to word", 72'(v), 72'(2));

        // R11 readback and unknown index
        cfg_write(8'hF1, 8'h5A);
        cfg_read(8'hF1, v);
        check(v == 8'h5A, "R11 readback", 72'(v), 72'(8'h5A));
        cfg_write(8'hF8, 8'hFD);
        cfg_read(8'hF8, v);
        check(v == 8'h01, "R11 size stores low bits", 72'(v), 72'(1));
        cfg_write(8'h40, 8'h77);
        cfg_read(8'h40, v);
        check(v == 8'h00, "R11 unknown index reads zero", 72'(v), 72'(0));

        // R2 R3 R5 word write, then R4 sizes at various latencies
        lat = 0; do_write(32'h1E78_9088, 32'h3000_0E00, 2'd2);
        lat = 2; do_write(32'hA0B0_C0D0, 32'hAABB_CCDD, 2'd0);
        lat = 1; do_write(32'h0000_0004, 32'hAABB_CCDD, 2'd1);
        lat = 3; do_write(32'hFFFF_FFFC, 32'h0102_0304, 2'd3);

        // R8 reads of several sizes
        lat = 3; do_read(32'h1234_5678, 2'd2, 32'h1122_3344);
        lat = 0; do_read(32'h0000_0010, 2'd0, 32'hDEAD_BEEF);
        lat = 4; do_read(32'h8000_0002, 2'd1, 32'hCAFE_F00D);

        // R9 triggers while busy are ignored
        lat = 6;
        hs0 = n_hs;
        load_regs(32'h0000_0100, 32'h1111_2222, 2'd2);
        exp_q.push_back({1'b1, 32'h0000_0100, 32'h2222_1111, 2'd2});
        cfg_write(8'hFE, 8'hCF);
        cfg_write(8'hFE, 8'hCF);
        cfg_read(8'hFE, v);
        check(v == 8'h01, "R6 busy reads one", 72'(v), 72'(1));
        wait_idle();
        repeat (4) @(negedge clk);
        check(n_hs == hs0 + 1, "R9 one cycle only", 72'(n_hs - hs0), 72'(1));

        // R5 other values on the trigger start nothing
        hs0 = n_hs;
        cfg_write(8'hFE, 8'h3C);
        repeat (3) @(negedge clk);
        check(!bus_req && n_hs == hs0, "R5 wrong key ignored", 72'(bus_req), 72'(0));

        // R10 inactive device
        cfg_write(8'hF0, 8'h42);
        dev_active = 1'b0;
        cfg_read(8'hF0, v);
        check(v == 8'h00, "R10 inactive read zero", 72'(v), 72'(0));
        cfg_write(8'hF0, 8'h99);
        cfg_write(8'hFE, 8'hCF);
        cfg_read(8'hFE, v);
        repeat (3) @(negedge clk);
        check(!bus_req && n_hs == hs0, "R10 inactive trigger ignored", 72'(bus_req), 72'(0));
        dev_active = 1'b1;
        cfg_read(8'hF0, v);
        check(v == 8'h42, "R10 inactive write ignored", 72'(v), 72'(8'h42));

        check(exp_q.size() == 0, "R7 all expected cycles seen", 72'(exp_q.size()), 72'(0));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule